// File: doc/BRIEF.md
# Secondary Bus Central Arbiter

This block arbitrates ownership of a shared secondary PCI-style bus between the bridge's own internal master and a set of external masters. Each master asks for the bus by pulling its active-low request line low. The arbiter answers with at most one active-low grant. Between waiting masters it rotates fairly. When nobody else wants the bus, it leaves the grant with whichever master used the bus last, so the bus stays parked there.

A master that keeps its request up while others wait can be forced off the bus. A time-to-preempt counter starts when another master begins waiting. When it reaches the programmed limit, the owner's grant is withdrawn. Preemption can be switched off. A strap input hands bus arbitration to an external device, and while that strap is high every grant output stays high.

Top module: `sec_bus_arbiter`

## Requirements
- R1: After reset, with the strap low, the bus is parked at the internal master (index 0): `gnt_no` equals all ones except bit 0, which is low.
- R2: At most one bit of `gnt_no` is low in any cycle.
- R3: Whenever the grant moves from one master to another, exactly one clock with all grant bits high lies between the two grants.
- R4: While no master other than the current owner requests, the owner keeps its grant, whether or not it still requests (parking at the last user).
- R5: If the owner does not request and another master does, the grant goes high on the next clock edge. On the edge after that, the chosen master is granted.
- R6: The next owner is the first requesting master found by counting upward from the current owner's index, wrapping from the highest index to 0.
- R7: With preemption enabled (`preempt_off_i` low), a requesting owner loses its grant on the L-th consecutive clock edge at which it and at least one other master both request, where L is the time-to-preempt.
- R8: With `preempt_off_i` high, a requesting owner keeps its grant for as long as it requests. If preemption is re-enabled after L or more such edges, the grant is removed at the next edge.
- R9: `tp_sel_i` sets L: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64, 4 gives 128, and 5 to 7 give 32.
- R10: The preemption count starts again from zero whenever no other master requests, and whenever ownership changes.
- R11: While `ext_arb_i` is high, all grant bits are high in the same cycle. When it falls, the bus is parked at the internal master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_arb_i | input | 1 | Strap: high selects an external arbiter and disables this one |
| preempt_off_i | input | 1 | High disables preemption; low (reset value) enables it |
| tp_sel_i | input | 3 | Time-to-preempt select |
| req_ni | input | NUM_EXT+1 | Active-low requests; bit 0 is the internal master |
| gnt_no | output | NUM_EXT+1 | Active-low one-hot grants; bit 0 is the internal master |

## Verification
Several properties are checked on every cycle: that at most one grant is low, that a handover always passes through an idle cycle, that the grant holds while nobody else requests or while preemption is off, and that the strap forces every grant high. The bench's scenarios are the only evidence for the round-robin choice, the exact edge on which preemption fires for each select encoding, and the restart of the count when a waiting master withdraws. The same holds for parking at the internal master after reset and after the strap is released.

// File: rtl/sba_pkg.sv
`timescale 1ns/1ps
package sba_pkg;
  localparam int unsigned TP_MAX = 128;
  localparam int unsigned CNT_W  = $clog2(TP_MAX) + 1;

  function automatic logic [CNT_W-1:0] tp_limit(input logic [2:0] sel);
    case (sel)
      3'd0:    tp_limit = CNT_W'(8);
      3'd1:    tp_limit = CNT_W'(16);
      3'd2:    tp_limit = CNT_W'(32);
      3'd3:    tp_limit = CNT_W'(64);
      3'd4:    tp_limit = CNT_W'(128);
      default: tp_limit = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/sba_rr_pick.sv
`timescale 1ns/1ps
module sba_rr_pick #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  // search starts one past last owner; last owner itself excluded
  always_comb begin
    idx_o   = last_i;
    valid_o = 1'b0;
    for (int k = 1; k < N; k++) begin
      int c;
      c = (int'(last_i) + k) % N;
      if (!valid_o && req_i[c]) begin
        idx_o   = IW'(c);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sba_preempt_timer.sv
`timescale 1ns/1ps
module sba_preempt_timer import sba_pkg::*; #(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         at_lim;

  assign at_lim    = (cnt_q >= limit_i - W'(1));
  assign expired_o = run_i && at_lim;

  // saturates so a late enable still fires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!at_lim) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/sec_bus_arbiter.sv
`timescale 1ns/1ps
module sec_bus_arbiter import sba_pkg::*; #(
  parameter  int NUM_EXT = 4,
  localparam int N       = NUM_EXT + 1,
  localparam int IW      = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_arb_i,
  input  logic         preempt_off_i,
  input  logic [2:0]   tp_sel_i,
  input  logic [N-1:0] req_ni,
  output logic [N-1:0] gnt_no
);
  logic [N-1:0]     req;
  logic [N-1:0]     owner_oh;
  logic [N-1:0]     others;
  logic             owner_req;
  logic [IW-1:0]    owner_q;
  logic             gap_q;
  logic [IW-1:0]    pick_idx;
  logic             pick_vld;
  logic             tmr_run;
  logic             tmr_exp;
  logic             do_switch;
  logic [CNT_W-1:0] limit;

  assign req       = ~req_ni;
  assign owner_oh  = N'(1) << owner_q;
  assign others    = req & ~owner_oh;
  assign owner_req = |(req & owner_oh);
  assign limit     = tp_limit(tp_sel_i);

  sba_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req_i   (others),
    .last_i  (owner_q),
    .idx_o   (pick_idx),
    .valid_o (pick_vld)
  );

  assign tmr_run = !ext_arb_i && !gap_q && pick_vld && owner_req;

  sba_preempt_timer #(.W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (tmr_run),
    .limit_i   (limit),
    .expired_o (tmr_exp)
  );

  assign do_switch = !ext_arb_i && !gap_q && pick_vld &&
                     (!owner_req || (!preempt_off_i && tmr_exp));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      gap_q   <= 1'b0;
    end else if (ext_arb_i) begin
      owner_q <= '0;
      gap_q   <= 1'b0;
    end else if (do_switch) begin
      owner_q <= pick_idx;
      gap_q   <= 1'b1;
    end else if (gap_q) begin
      gap_q   <= 1'b0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt_no[g] = ext_arb_i | gap_q | (owner_q != IW'(g));
  end
endmodule

// File: rtl/sba_chk.sv
`timescale 1ns/1ps
module sba_chk #(
  parameter int NUM_EXT = 4,
  localparam int N      = NUM_EXT + 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ext_arb_i,
  input logic         preempt_off_i,
  input logic [N-1:0] req_ni,
  input logic [N-1:0] gnt_no
);
  // R2
  onehot_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~gnt_no));

  // R3
  handover_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_no != '1) |=> (gnt_no == '1 || $stable(gnt_no)));

  // R4
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_no != '1 && ((~req_ni) & gnt_no) == '0) |=> (ext_arb_i || $stable(gnt_no)));

  // R8
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_no != '1 && preempt_off_i && ((~req_ni) & ~gnt_no) != '0)
      |=> (ext_arb_i || $stable(gnt_no)));

  // R11
  strap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_arb_i |-> (gnt_no == '1));
endmodule

bind sec_bus_arbiter sba_chk #(.NUM_EXT(NUM_EXT)) u_sba_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_arb_i     (ext_arb_i),
  .preempt_off_i (preempt_off_i),
  .req_ni        (req_ni),
  .gnt_no        (gnt_no)
);

// File: tb/tb_sec_bus_arbiter.sv
`timescale 1ns/1ps
module tb_sec_bus_arbiter;
  localparam int NE = 4;
  localparam int N  = NE + 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ext_arb_i = 1'b0;
  logic         preempt_off_i = 1'b0;
  logic [2:0]   tp_sel_i = 3'd2;
  logic [N-1:0] req_ni = '1;
  logic [N-1:0] gnt_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int m_owner = 0;
  bit m_gap   = 1'b0;
  int m_cnt   = 0;

  always #2.5 clk = ~clk;

  sec_bus_arbiter #(.NUM_EXT(NE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_arb_i(ext_arb_i),
    .preempt_off_i(preempt_off_i), .tp_sel_i(tp_sel_i),
    .req_ni(req_ni), .gnt_no(gnt_no)
  );

  function automatic int lim_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;
      3'd1: return 16;
      3'd3: return 64;
      3'd4: return 128;
      default: return 32;
    endcase
  endfunction

  function automatic int rr_next(input logic [N-1:0] r, input int o);
    for (int k = 1; k < N; k++) begin
      if (r[(o + k) % N]) return (o + k) % N;
    end
    return o;
  endfunction

  function automatic logic [N-1:0] g_exp();
    if (ext_arb_i || m_gap) return '1;
    return ~(N'(1) << m_owner);
  endfunction

  function automatic logic [N-1:0] one_low(input int i);
    return ~(N'(1) << i);
  endfunction

  task automatic model_step();
    logic [N-1:0] r;
    logic [N-1:0] oth;
    bit oreq;
    int lim;
    r = ~req_ni;
    lim = lim_of(tp_sel_i);
    if (ext_arb_i) begin
      m_owner = 0; m_gap = 1'b0; m_cnt = 0;
    end else if (m_gap) begin
      m_gap = 1'b0; m_cnt = 0;
    end else begin
      oth  = r & ~(N'(1) << m_owner);
      oreq = r[m_owner];
      if (oth == '0) m_cnt = 0;
      else if (!oreq || (!preempt_off_i && m_cnt >= lim - 1)) begin
        m_owner = rr_next(oth, m_owner); m_gap = 1'b1; m_cnt = 0;
      end else if (m_cnt < lim - 1) m_cnt++;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt_no=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 reset park", gnt_no, one_low(0));

    // R4: idle bus stays parked at internal
    repeat (3) cyc();
    chk("R4 idle park", gnt_no, one_low(0));

    // R5: owner idle, master 3 requests
    req_ni = one_low(3);
    cyc(); chk("R5 gap", gnt_no, '1);
    cyc(); chk("R5 grant", gnt_no, one_low(3));
    req_ni = '1;
    repeat (5) cyc();
    chk("R4 park last user", gnt_no, one_low(3));

    // R6: from 3 the order is 4,0,1,2
    req_ni = ~5'b10011;
    cyc(); cyc(); chk("R6 wrap pick 4", gnt_no, one_low(4));
    req_ni = ~5'b00011;
    cyc(); cyc(); chk("R6 pick 0", gnt_no, one_low(0));
    req_ni = ~5'b00110;
    cyc(); cyc(); chk("R6 pick 1", gnt_no, one_low(1));

    // R7: preempt owner 1 with L=8
    tp_sel_i = 3'd0;
    req_ni = ~5'b01010;
    repeat (7) cyc();
    chk("R7 before limit", gnt_no, one_low(1));
    cyc(); chk("R3 idle between", gnt_no, '1);
    cyc(); chk("R7 preempted to 3", gnt_no, one_low(3));

    // R9: unused code 7 gives 32
    tp_sel_i = 3'd7;
    req_ni = ~5'b01001;
    repeat (31) cyc();
    chk("R9 code7 before 32", gnt_no, one_low(3));
    cyc(); chk("R9 code7 at 32", gnt_no, '1);
    cyc(); chk("R9 next owner", gnt_no, one_low(0));

    // R10: waiting master withdraws for one cycle
    tp_sel_i = 3'd0;
    req_ni = ~5'b00101;
    repeat (5) cyc();
    req_ni = ~5'b00001;
    cyc();
    req_ni = ~5'b00101;
    repeat (7) cyc();
    chk("R10 restart", gnt_no, one_low(0));
    cyc(); chk("R10 fires after restart", gnt_no, '1);
    cyc(); chk("R10 new owner", gnt_no, one_low(2));

    // R8: preemption off
    preempt_off_i = 1'b1;
    req_ni = ~5'b10100;
    repeat (200) cyc();
    chk("R8 held while off", gnt_no, one_low(2));
    preempt_off_i = 1'b0;
    cyc(); chk("R8 late enable", gnt_no, '1);
    cyc(); chk("R8 owner 4", gnt_no, one_low(4));

    // R9: code 4 gives 128
    tp_sel_i = 3'd4;
    req_ni = ~5'b10010;
    repeat (127) cyc();
    chk("R9 code4 before 128", gnt_no, one_low(4));
    cyc(); chk("R9 code4 at 128", gnt_no, '1);
    cyc(); chk("R9 code4 owner", gnt_no, one_low(1));

    // R11: strap
    ext_arb_i = 1'b1;
    #1 chk("R11 strap high", gnt_no, '1);
    repeat (3) cyc();
    chk("R11 strap held", gnt_no, '1);
    req_ni = '1;
    cyc();
    ext_arb_i = 1'b0;
    #1 chk("R11 release park", gnt_no, one_low(0));
    @(negedge clk);

    // random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < 400; b++) begin
      int len;
      len = 1 + int'($urandom % 40);
      req_ni = N'($urandom);
      if (($urandom % 8) == 0) preempt_off_i = ~preempt_off_i;
      if (($urandom % 6) == 0) tp_sel_i = 3'($urandom);
      ext_arb_i = (($urandom % 30) == 0);
      for (int c = 0; c < len; c++) begin
        #1 chk("R6 random vs model", gnt_no, g_exp());
        cyc();
      end
    end
    chk("R2 random end", gnt_no, g_exp());

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule